// File: doc/BRIEF.md
# Lane-Interleaved Masked Vector Execution Unit

This block runs one element-wise integer vector instruction at a time over a vector register file. The register file is split across parallel lanes. Element `e` of every register is stored in lane `e mod LANES`, at row `e / LANES`. Each lane owns its slice and its own two-stage arithmetic pipeline, and never reads another lane's data. During issue, one group of `LANES` elements enters the pipelines on every clock. An element is written back only if it lies below the current vector length and, when masking is requested, only if its predicate bit is set. Masked-off elements still take their pipeline slot.

A set-length request loads the vector-length register with the smaller of the requested count and the hardware maximum. Loop code uses this to strip-mine long arrays. An element-granular write port and read port let a neighbouring load/store path fill and drain the register file.

A four-state sequencer controls the block:
- IDLE: waiting for work.
- ISSUE: one element group per cycle.
- DRAIN: three cycles while the pipelines empty and the last group lands.
- DONE: a one-cycle completion pulse.

The transitions are:
- IDLE→ISSUE: on an accepted start with a non-zero length.
- IDLE→DRAIN: on an accepted start with a zero length.
- ISSUE→DRAIN: after the last group issues.
- DRAIN→DONE: after three drain edges.
- DONE→IDLE: unconditionally.

Top module: `vec_lane_unit`

## Requirements
- R1: After reset the vector length reads MVL (16), and `busy` and `done` are low.
- R2: A set-length request sampled while idle makes `vl_out` equal min(`avl`, MVL) from the next cycle. While busy, set-length requests are ignored and `vl_out` holds.
- R3: Opcodes 0 = add, 1 = subtract (vs1 − vs2), 2 = AND, 3 = OR and 4 = XOR are applied per element as `vd[e] = vs1[e] op vs2[e]`, modulo 2^32.
- R4: Elements at index ≥ the vector length keep their previous value.
- R5: With `masked` high, element `e` is written only when bit 0 of element `e` of register 0 is 1; otherwise it keeps its value. With `masked` low, register 0 has no effect.
- R6: Let S be the clock edge at which a start is sampled while idle, and n = ceil(VL/LANES). Then `busy` is high from after S through the `done` cycle. `done` is high for exactly the one cycle after edge S+n+3, and `busy` falls at the next edge. Group k is written at edge S+k+3. Masking does not change this timing.
- R7: With a vector length of 0, no register changes and `done` is high in the cycle after edge S+3.
- R8: A start asserted while busy is ignored.
- R9: The element write port (`ew_reg`, `ew_idx`) updates only when idle and is ignored while busy. The read port returns element `er_idx` of register `er_reg` combinationally.
- R10: Opcodes 5 to 7 write no element but keep the R6 timing.
- R11: With LANES = 8 and a full length of 16, `done` is high after edge S+5. With 4 lanes it is high after edge S+7.
- R12: If a start and a set-length request are sampled at the same edge, the instruction uses the previous length, and `vl_out` takes the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an instruction (accepted when idle) |
| op | input | 3 | Operation code |
| vd | input | 5 | Destination register |
| vs1 | input | 5 | First source register |
| vs2 | input | 5 | Second source register |
| masked | input | 1 | Predicate writes with register 0 |
| setvl | input | 1 | Set-length request |
| avl | input | 8 | Requested element count |
| vl_out | output | 5 | Current vector length |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| ew_en | input | 1 | Element write strobe |
| ew_reg | input | 5 | Element write register |
| ew_idx | input | 4 | Element write index |
| ew_data | input | 32 | Element write data |
| er_reg | input | 5 | Element read register |
| er_idx | input | 4 | Element read index |
| er_data | output | 32 | Element read data |

## Verification
The bench targets the following corner cases, and what a wrong design would do in each:
- Tail elements past a short vector length: a unit that forgot the length limit would overwrite them.
- Masked elements: a unit that dropped the predicate would write every element, or one that shortened execution for masked slots would raise `done` early.
- A zero length, a request larger than the maximum, and a start coinciding with a set-length request: these show whether the clamp is missing or whether the new length is wrongly applied to the instruction in flight.
- Start, element writes and set-length requests aimed at a busy unit: a unit that accepted any of them would corrupt registers or the length.
- A second unit with eight lanes shows whether the completion time follows the lane count.

// File: rtl/vlu_pkg.sv
package vlu_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_DRAIN = 2'd2,
        S_DONE  = 2'd3
    } seq_state_e;

    localparam logic [2:0] OP_ADD = 3'd0;
    localparam logic [2:0] OP_SUB = 3'd1;
    localparam logic [2:0] OP_AND = 3'd2;
    localparam logic [2:0] OP_OR  = 3'd3;
    localparam logic [2:0] OP_XOR = 3'd4;

    // edges spent in DRAIN after the last issue edge
    localparam int DRAIN_EDGES = 3;
endpackage

// File: rtl/vlu_seq.sv
module vlu_seq
    import vlu_pkg::*;
#(
    parameter int LANES = 4,
    parameter int MVL   = 16,
    parameter int VLW   = 5,
    parameter int RW    = 2,
    parameter int AVLW  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            setvl,
    input  logic [AVLW-1:0] avl,
    output logic [VLW-1:0]  vl_q,
    output logic            accept,
    output logic            iss_v,
    output logic [RW-1:0]   iss_row,
    output logic            busy,
    output logic            done
);
    seq_state_e state_q, state_d;
    logic [RW-1:0] grp_q, last_q;
    logic [1:0]    dcnt_q;
    logic [VLW:0]  ngrp;

    always_comb begin
        accept = start && (state_q == S_IDLE);
        ngrp   = (VLW+1)'((32'(vl_q) + LANES - 1) / LANES);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = (vl_q == '0) ? S_DRAIN : S_ISSUE;
            S_ISSUE: if (grp_q == last_q) state_d = S_DRAIN;
            S_DRAIN: if (32'(dcnt_q) == DRAIN_EDGES - 1) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            grp_q   <= '0;
            last_q  <= '0;
            dcnt_q  <= '0;
            vl_q    <= VLW'(MVL);
        end else begin
            state_q <= state_d;
            if (accept) begin
                grp_q  <= '0;
                last_q <= RW'(ngrp - 1'b1);
            end else if (state_q == S_ISSUE) begin
                grp_q <= grp_q + 1'b1;
            end
            if (state_q != S_DRAIN) dcnt_q <= '0;
            else                    dcnt_q <= dcnt_q + 1'b1;
            if (setvl && state_q == S_IDLE)
                vl_q <= (32'(avl) > MVL) ? VLW'(MVL) : VLW'(avl);
        end
    end

    always_comb begin
        iss_v   = (state_q == S_ISSUE);
        iss_row = grp_q;
        busy    = (state_q != S_IDLE);
        done    = (state_q == S_DONE);
    end
endmodule

// File: rtl/vlu_lane.sv
module vlu_lane
    import vlu_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int ROWS  = 4,
    parameter int EW    = 32,
    parameter int LANES = 4,
    parameter int LANE  = 0,
    parameter int VLW   = 5,
    parameter int RW    = 2,
    parameter int RGW   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            iss_v,
    input  logic [RW-1:0]   iss_row,
    input  logic [VLW-1:0]  vl,
    input  logic [2:0]      op,
    input  logic [RGW-1:0]  vd,
    input  logic [RGW-1:0]  vs1,
    input  logic [RGW-1:0]  vs2,
    input  logic            masked,
    input  logic            xw_en,
    input  logic [RGW-1:0]  xw_reg,
    input  logic [RW-1:0]   xw_row,
    input  logic [EW-1:0]   xw_data,
    input  logic [RGW-1:0]  xr_reg,
    input  logic [RW-1:0]   xr_row,
    output logic [EW-1:0]   xr_data,
    output logic            wb_en
);
    logic [EW-1:0] rf [NREG][ROWS];

    logic          issue_we;
    int unsigned   elem;
    logic          s1_we, s2_we;
    logic [RW-1:0] s1_row, s2_row;
    logic [EW-1:0] s1_a, s1_b, s2_res, alu_y;

    always_comb begin
        elem     = 32'(iss_row) * LANES + LANE;
        issue_we = iss_v && (elem < 32'(vl)) && (op <= OP_XOR)
                   && (!masked || rf[0][iss_row][0]);
    end

    always_comb begin
        case (op)
            OP_ADD:  alu_y = s1_a + s1_b;
            OP_SUB:  alu_y = s1_a - s1_b;
            OP_AND:  alu_y = s1_a & s1_b;
            OP_OR:   alu_y = s1_a | s1_b;
            OP_XOR:  alu_y = s1_a ^ s1_b;
            default: alu_y = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_we  <= 1'b0;
            s2_we  <= 1'b0;
            s1_row <= '0;
            s2_row <= '0;
        end else begin
            s1_we  <= issue_we;
            s1_row <= iss_row;
            s2_we  <= s1_we;
            s2_row <= s1_row;
        end
    end

    always_ff @(posedge clk) begin
        s1_a   <= rf[vs1][iss_row];
        s1_b   <= rf[vs2][iss_row];
        s2_res <= alu_y;
        if (s2_we)      rf[vd][s2_row]     <= s2_res;
        else if (xw_en) rf[xw_reg][xw_row] <= xw_data;
    end

    always_comb begin
        xr_data = rf[xr_reg][xr_row];
        wb_en   = s2_we;
    end
endmodule

// File: rtl/vec_lane_unit.sv
module vec_lane_unit
    import vlu_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int MVL   = 16,
    parameter int LANES = 4,
    parameter int EW    = 32,
    parameter int AVLW  = 8,
    localparam int ROWS = MVL / LANES,
    localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int LW   = $clog2(LANES),
    localparam int IW   = $clog2(MVL),
    localparam int VLW  = $clog2(MVL + 1),
    localparam int RGW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [2:0]      op,
    input  logic [RGW-1:0]  vd,
    input  logic [RGW-1:0]  vs1,
    input  logic [RGW-1:0]  vs2,
    input  logic            masked,
    input  logic            setvl,
    input  logic [AVLW-1:0] avl,
    output logic [VLW-1:0]  vl_out,
    output logic            busy,
    output logic            done,
    input  logic            ew_en,
    input  logic [RGW-1:0]  ew_reg,
    input  logic [IW-1:0]   ew_idx,
    input  logic [EW-1:0]   ew_data,
    input  logic [RGW-1:0]  er_reg,
    input  logic [IW-1:0]   er_idx,
    output logic [EW-1:0]   er_data
);
    logic            accept, iss_v;
    logic [RW-1:0]   iss_row;
    logic [VLW-1:0]  vl_q, vl_lat;
    logic [2:0]      op_q;
    logic [RGW-1:0]  vd_q, vs1_q, vs2_q;
    logic            masked_q;
    logic [EW-1:0]   lane_rd [LANES];
    logic [LANES-1:0] lane_wb;
    logic            wb_any;

    vlu_seq #(.LANES(LANES), .MVL(MVL), .VLW(VLW), .RW(RW), .AVLW(AVLW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .setvl(setvl), .avl(avl),
        .vl_q(vl_q), .accept(accept), .iss_v(iss_v), .iss_row(iss_row),
        .busy(busy), .done(done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q <= '0; vd_q <= '0; vs1_q <= '0; vs2_q <= '0;
            masked_q <= 1'b0; vl_lat <= '0;
        end else if (accept) begin
            op_q <= op; vd_q <= vd; vs1_q <= vs1; vs2_q <= vs2;
            masked_q <= masked; vl_lat <= vl_q;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic xw_hit;
        assign xw_hit = ew_en && !busy && (32'(ew_idx[LW-1:0]) == l);
        vlu_lane #(.NREG(NREG), .ROWS(ROWS), .EW(EW), .LANES(LANES), .LANE(l),
                   .VLW(VLW), .RW(RW), .RGW(RGW)) u_lane (
            .clk(clk), .rst_n(rst_n), .iss_v(iss_v), .iss_row(iss_row),
            .vl(vl_lat), .op(op_q), .vd(vd_q), .vs1(vs1_q), .vs2(vs2_q),
            .masked(masked_q), .xw_en(xw_hit), .xw_reg(ew_reg),
            .xw_row(RW'(ew_idx >> LW)), .xw_data(ew_data),
            .xr_reg(er_reg), .xr_row(RW'(er_idx >> LW)),
            .xr_data(lane_rd[l]), .wb_en(lane_wb[l])
        );
    end

    always_comb begin
        vl_out  = vl_q;
        er_data = lane_rd[er_idx[LW-1:0]];
        wb_any  = |lane_wb;
    end
endmodule

// File: rtl/vlu_chk.sv
module vlu_chk #(
    parameter int MVL  = 16,
    parameter int AVLW = 8,
    parameter int VLW  = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            setvl,
    input logic [AVLW-1:0] avl,
    input logic [VLW-1:0]  vl_out,
    input logic            busy,
    input logic            done,
    input logic            wb_any
);
    AST_VL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        32'(vl_out) <= MVL); // R2
    AST_SETVL_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        setvl && !busy |=> 32'(vl_out) == ((32'($past(avl)) > MVL) ? MVL : 32'($past(avl)))); // R2
    AST_VL_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> vl_out == $past(vl_out)); // R2
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy); // R6
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done |=> busy); // R8
    AST_WB_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wb_any |-> busy); // R4
endmodule

bind vec_lane_unit vlu_chk #(.MVL(MVL), .AVLW(AVLW), .VLW(VLW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .setvl(setvl), .avl(avl),
    .vl_out(vl_out), .busy(busy), .done(done), .wb_any(wb_any)
);

// File: tb/vec_lane_unit_tb.sv
module vec_lane_unit_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        start = 0, start2 = 0, masked = 0, setvl = 0, ew_en = 0;
    logic [2:0]  op = 0;
    logic [4:0]  vd = 0, vs1 = 0, vs2 = 0, ew_reg = 0, er_reg = 0;
    logic [7:0]  avl = 0;
    logic [3:0]  ew_idx = 0, er_idx = 0;
    logic [31:0] ew_data = 0;
    logic [4:0]  vl_out, vl_out2;
    logic        busy, done, busy2, done2;
    logic [31:0] er_data, er_data2;

    vec_lane_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .vd(vd), .vs1(vs1),
        .vs2(vs2), .masked(masked), .setvl(setvl), .avl(avl), .vl_out(vl_out),
        .busy(busy), .done(done), .ew_en(ew_en), .ew_reg(ew_reg), .ew_idx(ew_idx),
        .ew_data(ew_data), .er_reg(er_reg), .er_idx(er_idx), .er_data(er_data)
    );

    vec_lane_unit #(.LANES(8)) u_dut8 (
        .clk(clk), .rst_n(rst_n), .start(start2), .op(op), .vd(vd), .vs1(vs1),
        .vs2(vs2), .masked(masked), .setvl(1'b0), .avl(avl), .vl_out(vl_out2),
        .busy(busy2), .done(done2), .ew_en(ew_en), .ew_reg(ew_reg), .ew_idx(ew_idx),
        .ew_data(ew_data), .er_reg(er_reg), .er_idx(er_idx), .er_data(er_data2)
    );

    int checks = 0, failures = 0;
    logic [31:0] m [32][16];
    int mvl_model = 16;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] f_op(input int o, input logic [31:0] a, input logic [31:0] b);
        case (o)
            0: return a + b;
            1: return a - b;
            2: return a & b;
            3: return a | b;
            default: return a ^ b;
        endcase
    endfunction

    task automatic compare_rf(input string req);
        bit ok = 1;
        logic [31:0] a = 0, e = 0;
        for (int r = 0; r < 32; r++)
            for (int x = 0; x < 16; x++) begin
                er_reg = 5'(r); er_idx = 4'(x); #1;
                if (ok && er_data !== m[r][x]) begin ok = 0; a = er_data; e = m[r][x]; end
            end
        check(ok, req, a, e);
    endtask

    task automatic do_setvl(input int n);
        @(negedge clk); setvl = 1; avl = 8'(n);
        @(negedge clk); setvl = 0;
        mvl_model = (n > 16) ? 16 : n;
        check(32'(vl_out) == mvl_model, "R2 set-length", 32'(vl_out), mvl_model);
    endtask

    task automatic run_op(input int o, input int d, input int a, input int b, input bit msk,
                          input bit disturb, input bit with_sv, input int sv_n, input string req);
        int vlu = mvl_model;
        int n = (vlu + 3) / 4;
        @(negedge clk);
        start = 1; op = 3'(o); vd = 5'(d); vs1 = 5'(a); vs2 = 5'(b); masked = msk;
        if (with_sv) begin setvl = 1; avl = 8'(sv_n); end
        @(posedge clk);
        @(negedge clk);
        start = 0; setvl = 0;
        if (with_sv) mvl_model = (sv_n > 16) ? 16 : sv_n;
        for (int c = 0; c <= n + 4; c++) begin
            if (c > 0) @(negedge clk);
            if (disturb && c == 1) begin
                start = 1; op = 0; vd = 5'd14; ew_en = 1; ew_reg = 5'd9; ew_idx = 4'd3;
                ew_data = 32'hDEAD_BEEF; setvl = 1; avl = 8'd2;
            end
            if (disturb && c == 2) begin start = 0; ew_en = 0; setvl = 0; end
            check(done == (c == n + 3), {req, " R6 done timing"}, 32'(done), 32'(c == n + 3));
            check(busy == (c <= n + 3), {req, " R6 busy timing"}, 32'(busy), 32'(c <= n + 3));
        end
        for (int i = 0; i < vlu; i++)
            if ((!msk || m[0][i][0]) && o <= 4)
                m[d][i] = f_op(o, m[a][i], m[b][i]);
        compare_rf({req, " register contents"});
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(vl_out == 5'd16, "R1 vl after reset", 32'(vl_out), 16);
        check(!busy && !done, "R1 busy/done after reset", {busy, done}, 0);

        // R9 fill the file through the element port
        for (int r = 0; r < 32; r++)
            for (int x = 0; x < 16; x++) begin
                logic [31:0] v = (32'(r) * 32'h9E37_79B1) ^ (32'(x) * 32'h0101_7F35) ^ 32'h5A5A_1234;
                if (r == 0) v = {v[31:1], (x % 3 == 0)};
                m[r][x] = v;
                ew_en = 1; ew_reg = 5'(r); ew_idx = 4'(x); ew_data = v;
                @(negedge clk);
            end
        ew_en = 0;
        compare_rf("R9 element port load");

        // R11 eight-lane unit: full length finishes after S+5
        begin
            int got = -1;
            op = 0; vd = 5'd20; vs1 = 5'd1; vs2 = 5'd2; masked = 0;
            start2 = 1;
            @(posedge clk);
            @(negedge clk);
            start2 = 0;
            for (int c = 0; c < 10; c++) begin
                if (c > 0) @(negedge clk);
                if (done2 && got < 0) got = c;
            end
            check(got == 5, "R11 eight-lane done cycle", 32'(got), 5);
        end

        run_op(0, 5, 1, 2, 0, 0, 0, 0, "R3 add full");
        run_op(1, 6, 3, 4, 1, 0, 0, 0, "R5 R3 masked sub");
        do_setvl(6);
        run_op(2, 7, 5, 6, 0, 0, 0, 0, "R4 and short length");
        run_op(3, 8, 2, 7, 1, 0, 0, 0, "R4 R5 masked or short");
        do_setvl(200);
        run_op(4, 9, 8, 1, 0, 1, 0, 0, "R8 R9 xor with busy disturbance");
        check(vl_out == 5'd16, "R2 set-length ignored while busy", 32'(vl_out), 16);
        do_setvl(0);
        run_op(0, 10, 1, 2, 0, 0, 0, 0, "R7 zero length");
        do_setvl(5);
        run_op(6, 11, 1, 2, 0, 0, 0, 0, "R10 unsupported opcode");
        run_op(0, 12, 3, 9, 0, 0, 1, 3, "R12 start with set-length");
        check(vl_out == 5'd3, "R12 new length after start", 32'(vl_out), 3);
        run_op(1, 0, 0, 13, 1, 0, 0, 0, "R5 mask register as destination");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule